// File: doc/BRIEF.md
# Receive Flow Control Trigger Unit

This block decides, once per clock, whether a receive port should push back on the link partner. It watches two sources of pressure. The first is buffer starvation: each receive channel reports how many free buffers it has and carries its own low-water threshold. The second is fill of the shared receive FIFO, measured in cells against a programmable FIFO threshold. Each source has its own feature enable. The FIFO source counts only while the port runs full duplex.

The block produces one registered flow-control request and a choice of response. In half duplex the request is marked for forced collisions. In full duplex it is marked for pause frames. The logic that jams the line or builds pause frames sits downstream and reads these outputs. The FIFO threshold sits in a small holding register. It is loaded by a strobe, forced into its legal window on load, and comes out of reset at a safe default.

Top module: `rx_flow_trigger`

## Requirements
- R1: A channel counts as starved when its enable bit is 1 and its free count is less than or equal to its threshold. A channel whose enable bit is 0 never contributes, whatever its counts are.
- R2: Buffer-based triggering requires `buf_fc_en` = 1. With it at 0, starved channels do not raise the request.
- R3: The FIFO condition is true when `fifo_level` is greater than or equal to the effective FIFO threshold.
- R4: The FIFO condition raises the request only when both `fifo_fc_en` = 1 and `full_duplex` = 1.
- R5: The effective FIFO threshold is 2 after reset. A load with `fifo_thresh_ld` = 1 stores `fifo_thresh_in` forced into the range 1 to 66: values below 1 become 1 and values above 66 become 66. The stored value takes effect from the clock edge that loads it.
- R6: The request stays 1 while any enabled trigger condition holds. It returns to 0 only when every condition has cleared.
- R7: `fc_pause` = 1 exactly when the request is 1 and `full_duplex` was 1. `fc_collide` = 1 exactly when the request is 1 and `full_duplex` was 0. The two are never 1 together.
- R8: All three outputs are registered. They reflect the inputs sampled at the previous rising clock edge and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_enable | input | NUM_CH | Per-channel enable for buffer-based triggering |
| chan_free | input | NUM_CH*CNT_W | Free-buffer count per channel; channel i is bits [i*CNT_W +: CNT_W] |
| chan_thresh | input | NUM_CH*CNT_W | Starvation threshold per channel, same packing as chan_free |
| buf_fc_en | input | 1 | Enables buffer-based triggering |
| fifo_fc_en | input | 1 | Enables FIFO-fill triggering |
| full_duplex | input | 1 | 1 = full duplex (pause frames), 0 = half duplex (collisions) |
| fifo_level | input | LVL_W | Receive FIFO occupancy in cells |
| fifo_thresh_ld | input | 1 | Load strobe for the FIFO threshold |
| fifo_thresh_in | input | LVL_W | New FIFO threshold value before range forcing |
| fc_request | output | 1 | Registered flow-control request |
| fc_collide | output | 1 | Request with the collision response selected |
| fc_pause | output | 1 | Request with the pause-frame response selected |

## Verification
The bench lands each comparison on its exact boundary. Free count equal to threshold must trigger and one above must not. FIFO level equal to threshold must trigger and one below must not. An off-by-one comparator fails one of these two checks. The threshold is loaded with 0, 200 and an in-range value, then probed at the edges of the forced range. A design that stored the raw value would trigger at level 0 or fail to trigger at 66. Disabled channels, a cleared feature enable and half-duplex operation are each driven with strong pressure present. Leaking any of these gates would raise a request. The bench also checks release with two overlapping causes, sampling before and after the first cause drops, so a request that falls early is caught. A last case switches duplex while a request is held, to check that the response marking follows the mode.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic [1:0] {
    FC_IDLE    = 2'd0,
    FC_COLLIDE = 2'd1,
    FC_PAUSE   = 2'd2
  } fc_mode_e;

  localparam int FIFO_TH_LO  = 1;
  localparam int FIFO_TH_HI  = 66;
  localparam int FIFO_TH_RST = 2;
endpackage

// File: rtl/rxfc_chan_cmp.sv
module rxfc_chan_cmp #(
  parameter int CNT_W = 8
) (
  input  logic             en,
  input  logic [CNT_W-1:0] free_cnt,
  input  logic [CNT_W-1:0] thresh,
  output logic             starved
);
  function automatic logic is_starved(input logic e,
                                      input logic [CNT_W-1:0] f,
                                      input logic [CNT_W-1:0] t);
    return e && (f <= t);
  endfunction

  assign starved = is_starved(en, free_cnt, thresh);

  // R1: a disabled channel never reports starvation
  always_comb begin
    if (!en) p_disabled_quiet_r1: assert (!starved);
  end
endmodule

// File: rtl/rxfc_fifo_cmp.sv
module rxfc_fifo_cmp #(
  parameter int LVL_W  = 8,
  parameter int TH_LO  = 1,
  parameter int TH_HI  = 66,
  parameter int TH_RST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [LVL_W-1:0] th_in,
  input  logic [LVL_W-1:0] level,
  output logic             over
);
  localparam logic [LVL_W-1:0] LO  = LVL_W'(TH_LO);
  localparam logic [LVL_W-1:0] HI  = LVL_W'(TH_HI);
  localparam logic [LVL_W-1:0] RST = LVL_W'(TH_RST);

  logic [LVL_W-1:0] th_q;

  function automatic logic [LVL_W-1:0] force_range(input logic [LVL_W-1:0] v);
    if (v < LO) return LO;
    if (v > HI) return HI;
    return v;
  endfunction

  function automatic logic reached(input logic [LVL_W-1:0] lv,
                                   input logic [LVL_W-1:0] th);
    return lv >= th;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  th_q <= RST;
    else if (ld) th_q <= force_range(th_in);
  end

  assign over = reached(level, th_q);

  p_thresh_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (th_q >= LO) && (th_q <= HI));

  p_load_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(th_q));
endmodule

// File: rtl/rx_flow_trigger.sv
module rx_flow_trigger
  import rxfc_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8,
  parameter int LVL_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       chan_enable,
  input  logic [NUM_CH*CNT_W-1:0] chan_free,
  input  logic [NUM_CH*CNT_W-1:0] chan_thresh,
  input  logic                    buf_fc_en,
  input  logic                    fifo_fc_en,
  input  logic                    full_duplex,
  input  logic [LVL_W-1:0]        fifo_level,
  input  logic                    fifo_thresh_ld,
  input  logic [LVL_W-1:0]        fifo_thresh_in,
  output logic                    fc_request,
  output logic                    fc_collide,
  output logic                    fc_pause
);
  logic [NUM_CH-1:0] chan_hit;
  logic              fifo_over;
  logic              buf_trig;
  logic              fifo_trig;
  fc_mode_e          mode_d, mode_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    rxfc_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
      .en       (chan_enable[i]),
      .free_cnt (chan_free[i*CNT_W +: CNT_W]),
      .thresh   (chan_thresh[i*CNT_W +: CNT_W]),
      .starved  (chan_hit[i])
    );
  end

  rxfc_fifo_cmp #(
    .LVL_W (LVL_W),
    .TH_LO (FIFO_TH_LO),
    .TH_HI (FIFO_TH_HI),
    .TH_RST(FIFO_TH_RST)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (fifo_thresh_ld),
    .th_in (fifo_thresh_in),
    .level (fifo_level),
    .over  (fifo_over)
  );

  assign buf_trig  = buf_fc_en && (|chan_hit);
  assign fifo_trig = fifo_fc_en && full_duplex && fifo_over;

  always_comb begin
    mode_d = FC_IDLE;
    if (buf_trig || fifo_trig) mode_d = full_duplex ? FC_PAUSE : FC_COLLIDE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= FC_IDLE;
    else        mode_q <= mode_d;
  end

  assign fc_request = (mode_q != FC_IDLE);
  assign fc_collide = (mode_q == FC_COLLIDE);
  assign fc_pause   = (mode_q == FC_PAUSE);

  p_buf_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_fc_en && (|chan_hit)) |=> fc_request);

  p_fifo_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_trig && !(fifo_fc_en && full_duplex)) |=> !fc_request);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_trig && !fifo_trig) |=> !fc_request);

  p_mode_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fc_collide, fc_pause}) && (fc_request == (fc_collide || fc_pause)));

  p_pause_duplex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_request && !fc_pause) |-> $past(!full_duplex));
endmodule

// File: tb/rx_flow_trigger_test.sv
module rx_flow_trigger_test;
  localparam int NUM_CH = 8;
  localparam int CNT_W  = 8;
  localparam int LVL_W  = 8;

  logic                    clk = 0;
  logic                    rst_n = 0;
  logic [NUM_CH-1:0]       chan_enable = '0;
  logic [NUM_CH*CNT_W-1:0] chan_free = '1;
  logic [NUM_CH*CNT_W-1:0] chan_thresh = '0;
  logic                    buf_fc_en = 0, fifo_fc_en = 0, full_duplex = 0;
  logic [LVL_W-1:0]        fifo_level = '0;
  logic                    fifo_thresh_ld = 0;
  logic [LVL_W-1:0]        fifo_thresh_in = '0;
  logic                    fc_request, fc_collide, fc_pause;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rx_flow_trigger #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .LVL_W(LVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .chan_enable(chan_enable), .chan_free(chan_free),
    .chan_thresh(chan_thresh), .buf_fc_en(buf_fc_en), .fifo_fc_en(fifo_fc_en),
    .full_duplex(full_duplex), .fifo_level(fifo_level),
    .fifo_thresh_ld(fifo_thresh_ld), .fifo_thresh_in(fifo_thresh_in),
    .fc_request(fc_request), .fc_collide(fc_collide), .fc_pause(fc_pause)
  );

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {req,coll,pause} got %b expected %b", req, got, exp);
    end
  endtask

  // expected outputs computed from the requirements
  function automatic logic [2:0] expect_out(input logic req_on, input logic fd);
    return {req_on, req_on && !fd, req_on && fd};
  endfunction

  function automatic logic [2:0] outs();
    return {fc_request, fc_collide, fc_pause};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_ch(input int i, input logic en, input int fr, input int th);
    chan_enable[i] = en;
    chan_free[i*CNT_W +: CNT_W]   = CNT_W'(fr);
    chan_thresh[i*CNT_W +: CNT_W] = CNT_W'(th);
  endtask

  task automatic clear_all();
    chan_enable = '0; chan_free = '1; chan_thresh = '0;
    buf_fc_en = 0; fifo_fc_en = 0; full_duplex = 0; fifo_level = '0;
    step();
  endtask

  task automatic load_th(input int v);
    fifo_thresh_ld = 1; fifo_thresh_in = LVL_W'(v);
    step();
    fifo_thresh_ld = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset", outs(), 3'b000);
  endtask

  task automatic t_channels();
    clear_all();
    buf_fc_en = 1;
    set_ch(3, 1, 10, 10); step();
    chk("R1 free==thresh", outs(), expect_out(1, 0));
    set_ch(3, 1, 11, 10); step();
    chk("R1 free>thresh", outs(), expect_out(0, 0));
    set_ch(5, 0, 0, 5); step();
    chk("R1 disabled channel", outs(), expect_out(0, 0));
    set_ch(7, 1, 0, 255); step();
    chk("R1 last channel", outs(), expect_out(1, 0));
    buf_fc_en = 0; step();
    chk("R2 buf enable off", outs(), expect_out(0, 0));
  endtask

  task automatic t_fifo_default();
    clear_all();
    fifo_fc_en = 1; full_duplex = 1;
    fifo_level = 1; step();
    chk("R5 reset thresh 2, level 1", outs(), expect_out(0, 1));
    fifo_level = 2; step();
    chk("R3 level==thresh", outs(), expect_out(1, 1));
    full_duplex = 0; fifo_level = 50; step();
    chk("R4 half duplex ignores fifo", outs(), expect_out(0, 0));
    full_duplex = 1; fifo_fc_en = 0; step();
    chk("R4 fifo enable off", outs(), expect_out(0, 1));
  endtask

  task automatic t_clamp();
    clear_all();
    fifo_fc_en = 1; full_duplex = 1;
    load_th(0);
    fifo_level = 0; step();
    chk("R5 low clamp, level 0", outs(), expect_out(0, 1));
    fifo_level = 1; step();
    chk("R5 low clamp, level 1", outs(), expect_out(1, 1));
    load_th(200);
    fifo_level = 65; step();
    chk("R5 high clamp, level 65", outs(), expect_out(0, 1));
    fifo_level = 66; step();
    chk("R5 high clamp, level 66", outs(), expect_out(1, 1));
    load_th(30);
    fifo_level = 29; step();
    chk("R3 level below thresh 30", outs(), expect_out(0, 1));
    fifo_level = 30; step();
    chk("R3 level at thresh 30", outs(), expect_out(1, 1));
  endtask

  task automatic t_hold();
    clear_all();
    full_duplex = 1; fifo_fc_en = 1; buf_fc_en = 1;
    fifo_level = 100; set_ch(0, 1, 1, 4); step();
    chk("R6 both causes", outs(), expect_out(1, 1));
    set_ch(0, 1, 9, 4); step();
    chk("R6 fifo still active", outs(), expect_out(1, 1));
    fifo_level = 0; step();
    chk("R6 all cleared", outs(), expect_out(0, 1));
  endtask

  task automatic t_mode_latency();
    clear_all();
    buf_fc_en = 1; full_duplex = 0;
    set_ch(2, 1, 0, 0);
    #5;
    chk("R8 before edge", outs(), 3'b000);
    step();
    chk("R7 collision mode", outs(), expect_out(1, 0));
    full_duplex = 1;
    #5;
    chk("R8 mode before edge", outs(), expect_out(1, 0));
    step();
    chk("R7 pause mode", outs(), expect_out(1, 1));
  endtask

  logic done = 0;

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_channels();
    t_fifo_default();
    t_clamp();
    t_hold();
    t_mode_latency();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule